// File: doc/BRIEF.md
# Hash Engine Status and Access-Violation Monitor

This block sits next to a block-hash engine on a simple word-addressed register bus. It produces the engine's read-only status word. The word carries a ready flag, which is raised when the core reports a finished 512-bit block. It also carries a sticky access-violation flag and a 3-bit code that names the most recent illegal register access. The block watches every bus strobe. It judges each access against the engine's busy, DMA and dual-buffer state as the access happens.

Start and software-reset pulses come from the control-register decode elsewhere in the engine. A software reset is the only way to clear the violation flag and the violation code. A one-cycle change pulse tells an external interrupt controller that one of the two flags has just risen. Read data is registered: a read strobe of the status address returns the word on the next cycle, and a read strobe of any other address returns zero.

Default register map (word addresses, all parameters):

| Address | Register | Access |
|---|---|---|
| 0 | control | write-only |
| 1 | mode | read/write |
| 2 | status | read-only |
| 16..31 | input data | write-only |
| 32..39 | output data | read-only |

Top module: `hash_status_mon`

## Requirements
- R1: After rst_ni is released, the status word reads 0 and status_chg_o is 0.
- R2: A cycle with block_done_i high makes status bit 0 (ready) read 1 from the next cycle on.
- R3: start_i or swrst_i clears the ready bit on the next cycle. A clear in the same cycle as block_done_i wins over the set.
- R4: Status bit 8 (violation flag) becomes 1 after any illegal access. It stays 1 through later accesses until swrst_i.
- R5: Status bits 14:12 hold the code of the most recent illegal access. Only swrst_i returns them to 0.
- R6: A write to an input data word (addresses 16..31) is illegal with code 0 when busy_i=1, dma_mode_i=1 and dual_buf_i=0. It is legal in every other state.
- R7: A read of an output data word (addresses 32..39) is illegal with code 1 while busy_i=1.
- R8: A write to the mode register (address 1) is illegal with code 2 while busy_i=1.
- R9: A read of a write-only register (control at address 0, or input data at 16..31) is illegal with code 3 in any engine state.
- R10: If swrst_i and an illegal access fall in the same cycle, the violation flag and the code both read 0 afterwards.
- R11: Status bits 31:15, 11:9 and 7:1 read 0. Writes to the status address (2) change nothing. A read strobe returns the status word one cycle later when the address is 2, and 0 for any other address.
- R12: status_chg_o is high for exactly the first cycle in which the ready flag or the violation flag reads 1 after having read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | One-cycle access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Word address |
| bus_rdata_o | output | 32 | Registered read data |
| busy_i | input | 1 | Engine is processing a block |
| dma_mode_i | input | 1 | Engine is fed by DMA |
| dual_buf_i | input | 1 | Dual input buffering is enabled |
| block_done_i | input | 1 | Pulse: a 512-bit block has finished |
| start_i | input | 1 | Pulse from control decode: start |
| swrst_i | input | 1 | Pulse from control decode: software reset |
| status_chg_o | output | 1 | Pulse when the ready flag or the violation flag rises |

## Verification
The bench uses the default parameters. AW=6 gives a 64-word address space, so every address can be swept: the control and mode words, the status word, the 16 input words, the 8 output words and the unmapped holes. Each address is tried for read and for write under all eight combinations of busy, DMA and dual-buffer state. The expected code is derived from the address range and the engine state. Directed sequences then cover the sticky behaviour, the last-code update, each same-cycle clear-versus-set case and the edge-only change pulse.

// File: rtl/hash_status_pkg.sv
package hash_status_pkg;
  localparam int RDY_BIT  = 0;
  localparam int VIOL_BIT = 8;
  localparam int CODE_LSB = 12;
  localparam int CODE_W   = 3;

  typedef enum logic [CODE_W-1:0] {
    ACC_DMA_WR  = 3'd0,
    ACC_OUT_RD  = 3'd1,
    ACC_MODE_WR = 3'd2,
    ACC_WO_RD   = 3'd3
  } acc_code_e;

  typedef struct packed {
    logic      rdy;
    logic      viol;
    acc_code_e code;
  } stat_t;

  function automatic logic [31:0] pack_status(stat_t s);
    logic [31:0] w;
    w = '0;
    w[RDY_BIT]                     = s.rdy;
    w[VIOL_BIT]                    = s.viol;
    w[CODE_LSB +: CODE_W]          = s.code;
    return w;
  endfunction
endpackage

// File: rtl/hash_addr_decode.sv
module hash_addr_decode #(
  parameter int AW        = 6,
  parameter int CTRL_ADDR = 0,
  parameter int MODE_ADDR = 1,
  parameter int STAT_ADDR = 2,
  parameter int IN_BASE   = 16,
  parameter int IN_N      = 16,
  parameter int OUT_BASE  = 32,
  parameter int OUT_N     = 8
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_ctrl_o,
  output logic          hit_mode_o,
  output logic          hit_stat_o,
  output logic          hit_in_o,
  output logic          hit_out_o
);
  logic [IN_N-1:0]  in_m;
  logic [OUT_N-1:0] out_m;

  for (genvar i = 0; i < IN_N; i++) begin : g_in
    assign in_m[i] = (addr_i == AW'(IN_BASE + i));
  end

  for (genvar j = 0; j < OUT_N; j++) begin : g_out
    assign out_m[j] = (addr_i == AW'(OUT_BASE + j));
  end

  assign hit_ctrl_o = (addr_i == AW'(CTRL_ADDR));
  assign hit_mode_o = (addr_i == AW'(MODE_ADDR));
  assign hit_stat_o = (addr_i == AW'(STAT_ADDR));
  assign hit_in_o   = |in_m;
  assign hit_out_o  = |out_m;
endmodule

// File: rtl/hash_access_check.sv
module hash_access_check
  import hash_status_pkg::*;
(
  input  logic      valid_i,
  input  logic      we_i,
  input  logic      hit_ctrl_i,
  input  logic      hit_mode_i,
  input  logic      hit_in_i,
  input  logic      hit_out_i,
  input  logic      busy_i,
  input  logic      dma_i,
  input  logic      dual_i,
  output logic      viol_o,
  output acc_code_e code_o
);
  logic wr, rd;
  assign wr = valid_i & we_i;
  assign rd = valid_i & ~we_i;

  // address classes are disjoint, so at most one branch can fire
  always_comb begin
    viol_o = 1'b0;
    code_o = ACC_DMA_WR;
    if (wr && hit_in_i && busy_i && dma_i && !dual_i) begin
      viol_o = 1'b1;
      code_o = ACC_DMA_WR;
    end else if (rd && hit_out_i && busy_i) begin
      viol_o = 1'b1;
      code_o = ACC_OUT_RD;
    end else if (wr && hit_mode_i && busy_i) begin
      viol_o = 1'b1;
      code_o = ACC_MODE_WR;
    end else if (rd && (hit_ctrl_i || hit_in_i)) begin
      viol_o = 1'b1;
      code_o = ACC_WO_RD;
    end
  end
endmodule

// File: rtl/hash_status_regs.sv
module hash_status_regs
  import hash_status_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      block_done_i,
  input  logic      start_i,
  input  logic      swrst_i,
  input  logic      viol_i,
  input  acc_code_e code_i,
  output stat_t     st_o,
  output logic      chg_o
);
  stat_t st_q, st_n;
  logic  chg_q, chg_n;

  always_comb begin
    st_n = st_q;
    if (block_done_i)       st_n.rdy = 1'b1;
    if (start_i || swrst_i) st_n.rdy = 1'b0;
    if (viol_i) begin
      st_n.viol = 1'b1;
      st_n.code = code_i;
    end
    if (swrst_i) begin
      st_n.viol = 1'b0;
      st_n.code = ACC_DMA_WR;
    end
    chg_n = (st_n.rdy & ~st_q.rdy) | (st_n.viol & ~st_q.viol);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '{rdy: 1'b0, viol: 1'b0, code: ACC_DMA_WR};
      chg_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      chg_q <= chg_n;
    end
  end

  assign st_o  = st_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/hash_status_mon.sv
module hash_status_mon
  import hash_status_pkg::*;
#(
  parameter int AW        = 6,
  parameter int CTRL_ADDR = 0,
  parameter int MODE_ADDR = 1,
  parameter int STAT_ADDR = 2,
  parameter int IN_BASE   = 16,
  parameter int IN_N      = 16,
  parameter int OUT_BASE  = 32,
  parameter int OUT_N     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_valid_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  output logic [31:0]   bus_rdata_o,
  input  logic          busy_i,
  input  logic          dma_mode_i,
  input  logic          dual_buf_i,
  input  logic          block_done_i,
  input  logic          start_i,
  input  logic          swrst_i,
  output logic          status_chg_o
);
  logic      hit_ctrl, hit_mode, hit_stat, hit_in, hit_out;
  logic      viol;
  acc_code_e code;
  stat_t     st;
  logic [31:0] rdata_q;

  hash_addr_decode #(
    .AW(AW), .CTRL_ADDR(CTRL_ADDR), .MODE_ADDR(MODE_ADDR), .STAT_ADDR(STAT_ADDR),
    .IN_BASE(IN_BASE), .IN_N(IN_N), .OUT_BASE(OUT_BASE), .OUT_N(OUT_N)
  ) u_dec (
    .addr_i     (bus_addr_i),
    .hit_ctrl_o (hit_ctrl),
    .hit_mode_o (hit_mode),
    .hit_stat_o (hit_stat),
    .hit_in_o   (hit_in),
    .hit_out_o  (hit_out)
  );

  hash_access_check u_acc (
    .valid_i    (bus_valid_i),
    .we_i       (bus_we_i),
    .hit_ctrl_i (hit_ctrl),
    .hit_mode_i (hit_mode),
    .hit_in_i   (hit_in),
    .hit_out_i  (hit_out),
    .busy_i     (busy_i),
    .dma_i      (dma_mode_i),
    .dual_i     (dual_buf_i),
    .viol_o     (viol),
    .code_o     (code)
  );

  hash_status_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .block_done_i (block_done_i),
    .start_i      (start_i),
    .swrst_i      (swrst_i),
    .viol_i       (viol),
    .code_i       (code),
    .st_o         (st),
    .chg_o        (status_chg_o)
  );

  // status write strobes fall through: nothing here decodes them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               rdata_q <= '0;
    else if (bus_valid_i && !bus_we_i && hit_stat) rdata_q <= pack_status(st);
    else                                       rdata_q <= '0;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/hash_status_mon_chk.sv
module hash_status_mon_chk #(
  parameter int AW        = 6,
  parameter int MODE_ADDR = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_valid_i,
  input logic          bus_we_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [31:0]   bus_rdata_o,
  input logic          busy_i,
  input logic          block_done_i,
  input logic          start_i,
  input logic          swrst_i,
  input logic          status_chg_o,
  input logic          rdy,
  input logic          viol,
  input logic [2:0]    code
);
  AST_RDY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_done_i && !start_i && !swrst_i |=> rdy); // R2
  AST_RDY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i || swrst_i |=> !rdy); // R3
  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol && !swrst_i |=> viol); // R4
  AST_MODE_WR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && bus_we_i && bus_addr_i == AW'(MODE_ADDR) && busy_i && !swrst_i
    |=> viol && code == 3'd2); // R8
  AST_SWRST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_i |=> !viol && code == 3'd0); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[31:15] == '0 && bus_rdata_o[11:9] == '0 && bus_rdata_o[7:1] == '0); // R11
  AST_CHG_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_chg_o |-> (rdy && !$past(rdy)) || (viol && !$past(viol))); // R12
endmodule

bind hash_status_mon hash_status_mon_chk #(.AW(AW), .MODE_ADDR(MODE_ADDR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_i  (bus_valid_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .busy_i       (busy_i),
  .block_done_i (block_done_i),
  .start_i      (start_i),
  .swrst_i      (swrst_i),
  .status_chg_o (status_chg_o),
  .rdy          (st.rdy),
  .viol         (st.viol),
  .code         (st.code)
);

// File: tb/hash_status_mon_tb.sv
module hash_status_mon_tb;
  localparam int AW = 6;
  localparam int STAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 0, we = 0, busy = 0, dma = 0, dual = 0, done = 0, start = 0, swrst = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] rdata;
  logic chg;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hash_status_mon u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_we_i(we),
    .bus_addr_i(addr), .bus_rdata_o(rdata), .busy_i(busy), .dma_mode_i(dma),
    .dual_buf_i(dual), .block_done_i(done), .start_i(start), .swrst_i(swrst),
    .status_chg_o(chg)
  );

  function automatic logic [31:0] word(logic r, logic v, logic [2:0] c);
    return (32'(c) << 12) | (32'(v) << 8) | 32'(r);
  endfunction

  // expected classification: bit 3 = illegal, bits 2:0 = code
  function automatic logic [3:0] classify(int a, logic w, logic b, logic d, logic du);
    bit in_w  = (a >= 16 && a <= 31);
    bit out_w = (a >= 32 && a <= 39);
    if (w && in_w && b && d && !du) return 4'b1_000;
    if (!w && out_w && b)           return 4'b1_001;
    if (w && a == 1 && b)           return 4'b1_010;
    if (!w && (a == 0 || in_w))     return 4'b1_011;
    return 4'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    valid = 0; we = 0; done = 0; start = 0; swrst = 0;
  endtask

  task automatic read_status(string req, logic [31:0] exp);
    idle(); busy = 0; valid = 1; we = 0; addr = AW'(STAT);
    step();
    idle();
    chk(req, rdata, exp);
  endtask

  task automatic do_swrst();
    idle(); swrst = 1; step(); idle();
  endtask

  task automatic access(logic w, int a, logic b, logic d, logic du);
    idle(); valid = 1; we = w; addr = AW'(a); busy = b; dma = d; dual = du;
    step();
    idle();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    logic [3:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk("R1 chg after reset", 32'(chg), 0);
    read_status("R1 status after reset", 0);

    // ready flag
    idle(); done = 1; step(); idle();
    chk("R12 chg on ready rise", 32'(chg), 1);
    step();
    chk("R12 chg one cycle", 32'(chg), 0);
    read_status("R2 ready set", word(1, 0, 0));
    access(1, STAT, 0, 0, 0);
    read_status("R11 status write ignored", word(1, 0, 0));
    idle(); done = 1; step(); idle();
    chk("R12 no chg when already ready", 32'(chg), 0);
    idle(); start = 1; step(); idle();
    read_status("R3 start clears ready", 0);
    idle(); done = 1; start = 1; step(); idle();
    chk("R12 no chg when clear wins", 32'(chg), 0);
    read_status("R3 start beats done", 0);
    idle(); done = 1; swrst = 1; step(); idle();
    read_status("R3 swrst beats done", 0);

    // sticky flag, last code
    access(1, 1, 1, 0, 0);
    chk("R12 chg on violation rise", 32'(chg), 1);
    access(0, 35, 1, 0, 0);
    chk("R12 no chg when flag already set", 32'(chg), 0);
    read_status("R5 last code kept", word(0, 1, 1));
    access(0, 1, 0, 0, 0);
    access(1, 20, 1, 1, 1);
    read_status("R4 flag stays through legal access", word(0, 1, 1));
    access(0, 0, 0, 0, 0);
    read_status("R5 code updates to 3", word(0, 1, 3));
    do_swrst();
    read_status("R4 swrst clears flag", 0);
    idle(); valid = 1; we = 0; addr = AW'(17); swrst = 1; step(); idle();
    chk("R10 no chg when swrst wins", 32'(chg), 0);
    read_status("R10 swrst beats violation", 0);

    // sweep: every address, read/write, every engine state
    for (int a = 0; a < (1 << AW); a++) begin
      for (int m = 0; m < 16; m++) begin
        do_swrst();
        access(m[3], a, m[2], m[1], m[0]);
        e = classify(a, m[3], m[2], m[1], m[0]);
        chk($sformatf("R6 R7 R8 R9 chg a=%0d m=%0d", a, m), 32'(chg), 32'(e[3]));
        chk($sformatf("R11 rdata after access a=%0d", a), rdata, 0);
        read_status($sformatf("R6 R7 R8 R9 status a=%0d m=%0d", a, m), word(0, e[3], e[2:0]));
      end
    end

    report();
  end
endmodule